// File: doc/BRIEF.md
# Edge/Level Interrupt Router

The router gathers up to 64 interrupt request lines. Each line is configured as edge-sensitive or level-sensitive. For every source it keeps a pending bit, an in-service bit, a mask bit, an edge-select bit, a polarity bit and a message-enable bit. It also keeps an 8-bit vector byte and an 8-bit route byte. When a source is raised and is not masked, its in-service bit is set and the output line named by its vector byte goes high. When a raised source stops being pending, the line goes low again.

Software uses a single-cycle register bus. The bus has a 12-bit byte address, a write strobe, 32-bit write data and combinational 32-bit read data. Each 64-bit per-source register is reached as two 32-bit words: address bit 2 selects the upper half. The vector and route tables are reached one byte per address. In any one clock cycle, only one raise and one lower are serviced. Each picks the lowest-numbered candidate source.

Address map (byte offsets): 0x000 identity word 0, 0x004 identity word 1, 0x020/0x024 mask, 0x040/0x044 message enable, 0x060/0x064 edge select (1 = edge), 0x080/0x084 clear (write only), 0x0C0/0x0C4/0x0E0/0x0E4 auto-control (discarded), 0x100+i route byte i, 0x200+i vector byte i, 0x300/0x304 status, 0x380/0x384 polarity.

Top module: `intr_router`

## Requirements
- R1: An edge-selected source becomes pending only when its input is high and the level sampled on the previous clock was low. A falling input leaves its pending bit set.
- R2: A level-selected source's pending bit equals its input as sampled on the previous clock edge.
- R3: A raise event considers the sources whose input rose or whose mask bit was just cleared, and which are pending and unmasked. The lowest-numbered such source gets its in-service bit set, and line_out[vector byte] is high from the next cycle.
- R4: A lower event considers the sources whose input fell, whose mask bit was just set, or which a clear write just cleared, and which are in service and not pending. The lowest-numbered such source gets its in-service bit cleared, and its vector's output line goes low. If a raise and a lower name the same line in one cycle, the raise wins.
- R5: A write to the mask word at 0x020 or 0x024 changes only that 32-bit half. Newly unmasked bits are judged as a raise event and newly masked bits as a lower event.
- R6: A write to the clear word at 0x080 or 0x084 acts only when its set bits overlap the edge-select bits of that half. When it acts, it clears those pending bits, runs a lower event for them, and then clears them in the in-service register. Otherwise it has no effect.
- R7: Status at 0x300 and 0x304 reads in-service AND NOT mask. Writing a status half overwrites that half of the in-service register.
- R8: Identity word 1 at 0x004 reads the version in bits 15:0 and NUM_SRC-1 in bits 31:16. Identity word 0 at 0x000 reads the ID_WORD parameter.
- R9: There are 64 vector bytes (0x200–0x23F) and 64 route bytes (0x100–0x13F). Each reads back what was last written to it, in bits 7:0. Bytes past entry 63, such as 0x140, read zero.
- R10: The polarity and message-enable halves read back what was written to them and have no effect on line_out.
- R11: A synchronous reset clears every state bit, every table byte and every output line.
- R12: The auto-control words and any unmapped address read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Interrupt request inputs |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| line_out | output | NUM_OUT | Routed output lines |

## Verification
The checker assumes a synchronous reset at start-up. It assumes irq_in and the bus signals change only between clock edges, so each clock edge sees one settled set of inputs. The line-tracking property also relies on the vector bytes staying inside NUM_OUT, which holds for the default 8-bit vectors and 256 lines. The stimulus drives every input on the falling clock edge. Random traffic toggles one request line per cycle and mixes in mask, clear, edge-select and status traffic. Directed cases make several sources rise in the same cycle, so that lowest-first selection is exercised.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;
  localparam int ADDR_W = 12;
  localparam logic [11:0] A_ID0     = 12'h000;
  localparam logic [11:0] A_ID1     = 12'h004;
  localparam logic [11:0] A_MASK_LO = 12'h020;
  localparam logic [11:0] A_MASK_HI = 12'h024;
  localparam logic [11:0] A_MSG_LO  = 12'h040;
  localparam logic [11:0] A_MSG_HI  = 12'h044;
  localparam logic [11:0] A_EDGE_LO = 12'h060;
  localparam logic [11:0] A_EDGE_HI = 12'h064;
  localparam logic [11:0] A_CLR_LO  = 12'h080;
  localparam logic [11:0] A_CLR_HI  = 12'h084;
  localparam logic [11:0] A_STAT_LO = 12'h300;
  localparam logic [11:0] A_STAT_HI = 12'h304;
  localparam logic [11:0] A_POL_LO  = 12'h380;
  localparam logic [11:0] A_POL_HI  = 12'h384;
  // 64-byte table pages selected by address bits 11:6
  localparam logic [5:0] PG_ROUTE = 6'h04;
  localparam logic [5:0] PG_VEC   = 6'h08;

  // replace one 32-bit half of a 64-bit register
  function automatic logic [63:0] put_half(logic [63:0] cur, logic [31:0] d, logic hi);
    return hi ? {d, cur[31:0]} : {cur[63:32], d};
  endfunction

  function automatic logic [31:0] get_half(logic [63:0] v, logic hi);
    return hi ? v[63:32] : v[31:0];
  endfunction

  // place a 32-bit word into the selected half of a 64-bit mask
  function automatic logic [63:0] spread_half(logic [31:0] d, logic hi);
    return hi ? {d, 32'h0} : {32'h0, d};
  endfunction
endpackage

// File: rtl/intr_capture.sv
module intr_capture #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] edge_q,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] pend_n,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] last_q;

  assign rise   = irq_in & ~last_q;
  assign fall   = ~irq_in & last_q;
  assign pend_n = ((edge_q & (pend_q | rise)) | (~edge_q & irq_in)) & ~clr_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      last_q <= '0;
    end else begin
      pend_q <= pend_n;
      last_q <= irq_in;
    end
  end
endmodule

// File: rtl/intr_pick.sv
module intr_pick #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/intr_lines.sv
module intr_lines #(
  parameter int NUM_OUT = 256,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               raise_hit,
  input  logic [VEC_W-1:0]   raise_line,
  input  logic               lower_hit,
  input  logic [VEC_W-1:0]   lower_line,
  output logic [NUM_OUT-1:0] line_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      line_out <= '0;
    end else begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (lower_hit && lower_line == VEC_W'(i)) line_out[i] <= 1'b0;
        if (raise_hit && raise_line == VEC_W'(i)) line_out[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/intr_router.sv
module intr_router
  import intr_router_pkg::*;
#(
  parameter int          NUM_SRC = 64,
  parameter int          NUM_OUT = 256,
  parameter int          VEC_W   = 8,
  parameter logic [15:0] VERSION = 16'h0001,
  parameter logic [31:0] ID_WORD = 32'h0700_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_OUT-1:0] line_out
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  function automatic logic [63:0] wid(logic [NUM_SRC-1:0] x);
    return 64'(x);
  endfunction

  logic [NUM_SRC-1:0] mask_q, edge_q, pol_q, msg_q, isr_q;
  logic [VEC_W-1:0]   vec_q   [NUM_SRC];
  logic [7:0]         route_q [NUM_SRC];

  // bus decode
  logic       hi_sel, wr_mask, wr_edge, wr_clr, wr_stat, wr_pol, wr_msg;
  logic       route_hit, vec_hit;
  logic [5:0] tbl_idx;
  assign hi_sel    = bus_addr[2];
  assign wr_mask   = bus_we && (bus_addr == A_MASK_LO || bus_addr == A_MASK_HI);
  assign wr_edge   = bus_we && (bus_addr == A_EDGE_LO || bus_addr == A_EDGE_HI);
  assign wr_clr    = bus_we && (bus_addr == A_CLR_LO  || bus_addr == A_CLR_HI);
  assign wr_stat   = bus_we && (bus_addr == A_STAT_LO || bus_addr == A_STAT_HI);
  assign wr_pol    = bus_we && (bus_addr == A_POL_LO  || bus_addr == A_POL_HI);
  assign wr_msg    = bus_we && (bus_addr == A_MSG_LO  || bus_addr == A_MSG_HI);
  assign route_hit = (bus_addr[11:6] == PG_ROUTE);
  assign vec_hit   = (bus_addr[11:6] == PG_VEC);
  assign tbl_idx   = bus_addr[5:0];

  // mask and clear events
  logic [NUM_SRC-1:0] mask_n, unmask_bits, newmask_bits, clr_word, clr_bits;
  logic               clr_act;
  assign mask_n       = wr_mask ? NUM_SRC'(put_half(wid(mask_q), bus_wdata, hi_sel)) : mask_q;
  assign unmask_bits  = mask_q & ~mask_n;
  assign newmask_bits = ~mask_q & mask_n;
  assign clr_word     = wr_clr ? NUM_SRC'(spread_half(bus_wdata, hi_sel)) : '0;
  assign clr_act      = |(clr_word & edge_q);
  assign clr_bits     = clr_act ? clr_word : '0;

  // request capture
  logic [NUM_SRC-1:0] pend_q, pend_n, rise, fall;
  intr_capture #(.N(NUM_SRC)) u_capture (
    .clk(clk), .rst(rst), .irq_in(irq_in), .edge_q(edge_q), .clr_bits(clr_bits),
    .pend_q(pend_q), .pend_n(pend_n), .rise(rise), .fall(fall)
  );

  // raise / lower selection, lowest index first
  logic [NUM_SRC-1:0] raise_req, lower_req;
  logic               raise_hit, lower_hit;
  logic [IDX_W-1:0]   raise_idx, lower_idx;
  assign raise_req = (rise | unmask_bits) & pend_n & ~mask_n;
  assign lower_req = (fall | newmask_bits | clr_bits) & isr_q & ~pend_n;

  intr_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick_raise (
    .req(raise_req), .hit(raise_hit), .idx(raise_idx)
  );
  intr_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick_lower (
    .req(lower_req), .hit(lower_hit), .idx(lower_idx)
  );

  logic [VEC_W-1:0] raise_line, lower_line;
  assign raise_line = vec_q[raise_idx];
  assign lower_line = vec_q[lower_idx];

  // in-service update
  logic [NUM_SRC-1:0] raise_oh, lower_oh, isr_mid, isr_n;
  assign raise_oh = raise_hit ? (NUM_SRC'(1) << raise_idx) : '0;
  assign lower_oh = lower_hit ? (NUM_SRC'(1) << lower_idx) : '0;
  assign isr_mid  = (isr_q | raise_oh) & ~lower_oh & ~clr_bits;
  assign isr_n    = wr_stat ? NUM_SRC'(put_half(wid(isr_mid), bus_wdata, hi_sel)) : isr_mid;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      edge_q <= '0;
      pol_q  <= '0;
      msg_q  <= '0;
      isr_q  <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        vec_q[i]   <= '0;
        route_q[i] <= '0;
      end
    end else begin
      mask_q <= mask_n;
      isr_q  <= isr_n;
      if (wr_edge) edge_q <= NUM_SRC'(put_half(wid(edge_q), bus_wdata, hi_sel));
      if (wr_pol)  pol_q  <= NUM_SRC'(put_half(wid(pol_q), bus_wdata, hi_sel));
      if (wr_msg)  msg_q  <= NUM_SRC'(put_half(wid(msg_q), bus_wdata, hi_sel));
      for (int i = 0; i < NUM_SRC; i++) begin
        if (bus_we && vec_hit && tbl_idx == 6'(i))   vec_q[i]   <= bus_wdata[VEC_W-1:0];
        if (bus_we && route_hit && tbl_idx == 6'(i)) route_q[i] <= bus_wdata[7:0];
      end
    end
  end

  intr_lines #(.NUM_OUT(NUM_OUT), .VEC_W(VEC_W)) u_lines (
    .clk(clk), .rst(rst),
    .raise_hit(raise_hit), .raise_line(raise_line),
    .lower_hit(lower_hit), .lower_line(lower_line),
    .line_out(line_out)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_ID0:                bus_rdata = ID_WORD;
      A_ID1:                bus_rdata = {16'(NUM_SRC - 1), VERSION};
      A_MASK_LO, A_MASK_HI: bus_rdata = get_half(wid(mask_q), hi_sel);
      A_EDGE_LO, A_EDGE_HI: bus_rdata = get_half(wid(edge_q), hi_sel);
      A_MSG_LO,  A_MSG_HI:  bus_rdata = get_half(wid(msg_q), hi_sel);
      A_POL_LO,  A_POL_HI:  bus_rdata = get_half(wid(pol_q), hi_sel);
      A_STAT_LO, A_STAT_HI: bus_rdata = get_half(wid(isr_q & ~mask_q), hi_sel);
      default: begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (route_hit && tbl_idx == 6'(i)) bus_rdata = {24'h0, route_q[i]};
          if (vec_hit && tbl_idx == 6'(i))   bus_rdata = 32'(vec_q[i]);
        end
      end
    endcase
  end
endmodule

// File: rtl/intr_router_chk.sv
module intr_router_chk #(
  parameter int N       = 64,
  parameter int NUM_OUT = 256,
  parameter int VEC_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [N-1:0]       irq_in,
  input logic [N-1:0]       edge_q,
  input logic [N-1:0]       pend_q,
  input logic [N-1:0]       isr_q,
  input logic [N-1:0]       clr_bits,
  input logic               wr_stat,
  input logic               raise_hit,
  input logic [VEC_W-1:0]   raise_line,
  input logic [NUM_OUT-1:0] line_out
);
  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (line_out == '0 && isr_q == '0 && pend_q == '0));

  assert_level_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pend_q & ~$past(edge_q)) ==
                     ($past(irq_in) & ~$past(edge_q) & ~$past(clr_bits))));

  assert_edge_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(pend_q & edge_q & ~clr_bits) & ~pend_q) == '0));

  assert_raise_line_R3: assert property (@(posedge clk) disable iff (rst)
    raise_hit |=> line_out[$past(raise_line)]);

  // R4: without clear or status writes, at most one raise and one lower per cycle
  assert_isr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_stat) && $past(clr_bits) == '0)
      |-> ($countones(isr_q ^ $past(isr_q)) <= 2));
endmodule

bind intr_router intr_router_chk #(.N(NUM_SRC), .NUM_OUT(NUM_OUT), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .edge_q(edge_q), .pend_q(pend_q),
  .isr_q(isr_q), .clr_bits(clr_bits), .wr_stat(wr_stat),
  .raise_hit(raise_hit), .raise_line(raise_line), .line_out(line_out)
);

// File: tb/intr_router_bench.sv
`timescale 1ns/1ps
module intr_router_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic [63:0]  irq_in;
  logic [11:0]  bus_addr;
  logic         bus_we;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [255:0] line_out;

  always #5 clk = ~clk;

  intr_router u_intr_router (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_out(line_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  bit [63:0]  m_mask, m_edge, m_pend, m_last, m_isr, m_pol, m_msg;
  bit [7:0]   m_vec [64];
  bit [7:0]   m_route [64];
  bit [255:0] m_out;
  bit [63:0]  cur_irq;
  bit [31:0]  rd_val;

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    m_mask = 0; m_edge = 0; m_pend = 0; m_last = 0; m_isr = 0; m_pol = 0; m_msg = 0;
    m_out = 0;
    for (int i = 0; i < 64; i++) begin m_vec[i] = 0; m_route[i] = 0; end
  endfunction

  function automatic int lowest(bit [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit [63:0] half_in(bit [63:0] cur, bit [31:0] d, bit hi);
    bit [63:0] r = cur;
    if (hi) r[63:32] = d; else r[31:0] = d;
    return r;
  endfunction

  function automatic bit [31:0] m_read(bit [11:0] a);
    bit hi = a[2];
    bit [63:0] stat = m_isr & ~m_mask;
    case (a)
      12'h000: return 32'h0700_0000;
      12'h004: return {16'd63, 16'h0001};
      12'h020, 12'h024: return hi ? m_mask[63:32] : m_mask[31:0];
      12'h040, 12'h044: return hi ? m_msg[63:32]  : m_msg[31:0];
      12'h060, 12'h064: return hi ? m_edge[63:32] : m_edge[31:0];
      12'h300, 12'h304: return hi ? stat[63:32]   : stat[31:0];
      12'h380, 12'h384: return hi ? m_pol[63:32]  : m_pol[31:0];
      default: begin
        if (a[11:6] == 6'h04) return {24'h0, m_route[a[5:0]]};
        if (a[11:6] == 6'h08) return {24'h0, m_vec[a[5:0]]};
        return 32'h0;
      end
    endcase
  endfunction

  function automatic void model_tick(bit [63:0] irq, bit we, bit [11:0] a, bit [31:0] d);
    bit hi = a[2];
    bit [63:0] nm = m_mask, cw = 0, clrb, rise, fall, np, unm, nwm;
    int r, l;
    if (we && (a == 12'h020 || a == 12'h024)) nm = half_in(m_mask, d, hi);
    if (we && (a == 12'h080 || a == 12'h084)) cw = half_in(64'h0, d, hi);
    clrb = ((cw & m_edge) != 0) ? cw : 64'h0;
    rise = irq & ~m_last;
    fall = ~irq & m_last;
    for (int i = 0; i < 64; i++) np[i] = m_edge[i] ? (m_pend[i] | rise[i]) : irq[i];
    np &= ~clrb;
    unm = m_mask & ~nm;
    nwm = ~m_mask & nm;
    r = lowest((rise | unm) & np & ~nm);
    l = lowest((fall | nwm | clrb) & m_isr & ~np);
    if (l >= 0) begin m_isr[l] = 1'b0; m_out[m_vec[l]] = 1'b0; end
    if (r >= 0) begin m_isr[r] = 1'b1; m_out[m_vec[r]] = 1'b1; end
    m_isr &= ~clrb;
    if (we) begin
      if (a == 12'h300 || a == 12'h304) m_isr  = half_in(m_isr, d, hi);
      if (a == 12'h060 || a == 12'h064) m_edge = half_in(m_edge, d, hi);
      if (a == 12'h380 || a == 12'h384) m_pol  = half_in(m_pol, d, hi);
      if (a == 12'h040 || a == 12'h044) m_msg  = half_in(m_msg, d, hi);
      if (a[11:6] == 6'h04) m_route[a[5:0]] = d[7:0];
      if (a[11:6] == 6'h08) m_vec[a[5:0]]   = d[7:0];
    end
    m_mask = nm;
    m_pend = np;
    m_last = irq;
  endfunction

  // one bus/irq cycle; read compared to model, lines compared after the edge
  task automatic step(bit we, bit [11:0] a, bit [31:0] d, bit do_rd, string tag);
    @(negedge clk);
    irq_in = cur_irq; bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
    rd_val = bus_rdata;
    if (do_rd) chk({tag, " read"}, 256'(bus_rdata), 256'(m_read(a)));
    @(posedge clk);
    model_tick(cur_irq, we, a, d);
    #1;
    chk("R3/R4 lines", line_out, m_out);
  endtask

  task automatic wr(bit [11:0] a, bit [31:0] d, string tag);
    step(1'b1, a, d, 1'b0, tag);
  endtask

  task automatic rd(bit [11:0] a, string tag);
    step(1'b0, a, 32'h0, 1'b1, tag);
  endtask

  task automatic set_irq(int i, bit v);
    cur_irq[i] = v;
    step(1'b0, 12'h000, 32'h0, 1'b0, "irq");
  endtask

  task automatic random_phase();
    int op;
    int j;
    for (int k = 0; k < 600; k++) begin
      op = $urandom_range(0, 9);
      if (op < 6) begin
        j = $urandom_range(0, 63);
        cur_irq[j] = ~cur_irq[j];
        step(1'b0, 12'h000, 32'h0, 1'b0, "R1/R2 random");
      end else if (op == 6) begin
        wr($urandom_range(0, 1) ? 12'h024 : 12'h020, $urandom & $urandom, "R5 random mask");
      end else if (op == 7) begin
        wr($urandom_range(0, 1) ? 12'h084 : 12'h080, $urandom & $urandom & $urandom, "R6 random clear");
      end else if (op == 8) begin
        rd($urandom_range(0, 1) ? 12'h304 : 12'h300, "R7 random status");
      end else begin
        wr($urandom_range(0, 1) ? 12'h064 : 12'h060, $urandom, "R1 random edge");
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; irq_in = '0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    cur_irq = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R11 lines after reset", line_out, 256'h0);
    @(negedge clk); rst = 1'b0;

    rd(12'h300, "R11 status");
    chk("R11 status zero", 256'(rd_val), 256'h0);
    rd(12'h004, "R8 id1");
    chk("R8 id word", 256'(rd_val), 256'({16'd63, 16'h0001}));
    rd(12'h000, "R8 id0");

    wr(12'h105, 32'h1234_56A5, "R9");
    rd(12'h105, "R9 route");
    chk("R9 route byte", 256'(rd_val), 256'h0A5);
    rd(12'h140, "R9 past end");
    chk("R9 past table", 256'(rd_val), 256'h0);
    wr(12'h140, 32'hFF, "R9");
    rd(12'h100, "R9 route 0");
    chk("R9 ignored write", 256'(rd_val), 256'h0);

    wr(12'h384, 32'hDEAD_BEEF, "R10");
    rd(12'h384, "R10 pol");
    chk("R10 polarity", 256'(rd_val), 256'hDEAD_BEEF);
    wr(12'h040, 32'h0F0F_0F0F, "R10");
    rd(12'h040, "R10 msg");
    chk("R10 msg enable", 256'(rd_val), 256'h0F0F_0F0F);

    wr(12'h0C0, 32'hFFFF_FFFF, "R12");
    rd(12'h0C0, "R12 auto");
    chk("R12 auto reads zero", 256'(rd_val), 256'h0);
    rd(12'h020, "R12 mask untouched");
    chk("R12 mask unchanged", 256'(rd_val), 256'h0);

    for (int i = 0; i < 64; i++) wr(12'h200 + 12'(i), 32'((i * 3 + 1) & 255), "R9 vec");
    rd(12'h228, "R9 vec 40");
    chk("R9 vector byte", 256'(rd_val), 256'd121);
    wr(12'h060, 32'h0000_FFFF, "R1 edge cfg");

    // R1: edge source 3 -> line 10
    set_irq(3, 1);
    chk("R1 edge raise line", 256'(line_out[10]), 256'd1);
    set_irq(3, 0);
    chk("R1 falling keeps line", 256'(line_out[10]), 256'd1);
    wr(12'h080, 32'h8, "R6 clear");
    chk("R6 clear drops line", 256'(line_out[10]), 256'd0);
    rd(12'h300, "R6 status");
    chk("R6 status after clear", 256'(rd_val), 256'h0);

    // R2: level source 40 -> line 121
    set_irq(40, 1);
    chk("R2 level high", 256'(line_out[121]), 256'd1);
    set_irq(40, 0);
    chk("R2 level low", 256'(line_out[121]), 256'd0);

    // R5: masking
    set_irq(40, 1);
    wr(12'h024, 32'h300, "R5 mask hi");
    chk("R5 mask while pending keeps line", 256'(line_out[121]), 256'd1);
    rd(12'h304, "R5 status masked");
    chk("R5 status hides masked", 256'(rd_val), 256'h0);
    set_irq(40, 0);
    chk("R5 masked fall lowers", 256'(line_out[121]), 256'd0);
    set_irq(41, 1);
    chk("R5 masked no raise", 256'(line_out[124]), 256'd0);
    wr(12'h024, 32'h0, "R5 unmask");
    chk("R5 unmask raises", 256'(line_out[124]), 256'd1);

    // R6: clear without edge overlap ignored
    wr(12'h084, 32'h200, "R6 level clear");
    chk("R6 no-overlap clear ignored", 256'(line_out[124]), 256'd1);
    rd(12'h304, "R6 status hi");
    chk("R6 status kept", 256'(rd_val), 256'h200);

    // R7: status write
    wr(12'h304, 32'h0, "R7 status write");
    rd(12'h304, "R7 status hi");
    chk("R7 status overwritten", 256'(rd_val), 256'h0);
    set_irq(41, 0);

    // R3: two simultaneous rises, lowest first
    cur_irq[4] = 1'b1;
    set_irq(2, 1);
    chk("R3 lowest raised", 256'(line_out[7]), 256'd1);
    chk("R3 higher not raised", 256'(line_out[13]), 256'd0);
    rd(12'h300, "R3 status");
    chk("R3 status one source", 256'(rd_val), 256'h4);

    random_phase();

    // R11: reset mid-run
    @(negedge clk); rst = 1'b1; cur_irq = '0; irq_in = '0; bus_we = 1'b0;
    @(posedge clk); #1;
    model_reset();
    chk("R11 lines cleared", line_out, 256'h0);
    @(negedge clk); rst = 1'b0;
    rd(12'h200, "R11 vec");
    chk("R11 vec cleared", 256'(rd_val), 256'h0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule